// File: doc/BRIEF.md
# Serial ADC Controller with Power-Down

This block sits on the host side of a 12-bit successive-approximation converter that has a chip-select and a serial clock. It frames each conversion by pulling chip-select low and toggling the serial clock. It shifts in the converter's data line and hands the 12-bit result back as a one-cycle pulse. Sample requests arrive over a valid/ready handshake.

The converter's power state is set only by where in a frame chip-select returns high. The controller keeps its own copy of that state. A shutdown request, or the sleep-between-samples option, produces a short frame that ends after the fourth serial-clock falling edge, which sends the converter to sleep. A sample requested while the converter sleeps first gets a full-length wake frame. That frame's bits are thrown away, and the real conversion follows.

Every frame is followed by a chip-select-high gap. The gap is long enough that a full conversion frame plus its gap never exceeds the converter's 250 kSPS ceiling.

Top module: `adc_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `adc_cs_n` is 1, `adc_sclk` is 1, `res_valid` is 0 and `pwr_awake` is 1 (after reset the converter is taken to be in normal mode).
- R2: The frame format is as follows.
  - A conversion frame holds `adc_cs_n` low for exactly 16 `adc_sclk` low/high cycles, and `adc_sclk` idles high whenever `adc_cs_n` is high.
  - The data line changes after each falling edge and is captured at the following rising edge. Bit order is four leading zeros, then D11 down to D0.
  - `res_data` carries the last 12 captured bits, with D11 in bit 11. It is presented with a one-cycle `res_valid` pulse in the clock in which `adc_cs_n` returns high.
- R3: A sample request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the controller is idle with `adc_cs_n` high, and the accepted request starts a frame on the next clock.
- R4: When idle with the converter awake, `sd_req` high and `req_valid` low, the controller runs a shutdown frame. In that frame `adc_cs_n` rises after exactly the 4th `adc_sclk` falling edge. `pwr_awake` goes low in that clock, and the frame produces no `res_valid`.
- R5: `sd_req` has no effect while the converter is asleep: no frame starts and `adc_cs_n` stays high.
- R6: A sample requested while asleep first runs a 16-cycle wake frame. That frame produces no `res_valid`, and `pwr_awake` rises when it ends. The conversion frame follows and yields exactly one result.
- R7: With `sleep_en` high, every conversion frame is followed by a shutdown frame, so the converter is asleep once the controller is idle again.
- R8: Between any two frames `adc_cs_n` stays high for at least GAP = max(GAP_MIN, ceil(CLK_HZ/250000) − 33·SCLK_HALF) clocks. The distance from one falling edge of `adc_cs_n` to the next is at least ceil(CLK_HZ/250000) clocks whenever the earlier frame was full length.
- R9: If `req_valid` and `sd_req` are both high in the same idle cycle, the sample is taken first and its result delivered. Only after that does the shutdown frame run.
- R10: `pwr_awake` changes only in the clock where `adc_cs_n` rises. It falls only when that frame had 2 to 9 `adc_sclk` falling edges, and it rises only when the frame had 10 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Controller idle, request can be taken |
| sd_req | input | 1 | Level request to put the converter to sleep |
| sleep_en | input | 1 | Sleep after every sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Converted sample, MSB in bit DATA_W-1 |
| pwr_awake | output | 1 | Tracked converter power state, 1 = normal mode |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_sdata | input | 1 | Converter serial data |

## Verification
The two functions that can meet in one cycle are a sample request and a shutdown request. The bench raises `req_valid` and `sd_req` on the same idle cycle and holds `sd_req` until the power state drops. It then judges the order: the result count must already include the new sample when `pwr_awake` falls, and exactly two frames must have run. A second overlap comes from sleep-between-samples mode. There a new request arrives while a shutdown is pending, so a wake, a conversion and a shutdown must chain with the rate gap enforced before each.

// File: rtl/adc_ctl_pkg.sv
// Package: shared types for the serial ADC controller.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_ctl_pkg;

    // Kind of frame currently on the wire
    typedef enum logic [1:0] {
        FK_CONV = 2'd0,
        FK_WAKE = 2'd1,
        FK_SHUT = 2'd2
    } frame_kind_e;

    // Top-level sequencing state
    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FRAME = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/adc_frame_seq.sv
// Module: adc_frame_seq
// Generates chip-select and serial clock for one frame and counts the
// serial-clock falling edges. A frame starts with a half period of SCLK
// high, runs edge_target low/high cycles and then raises CS at the moment
// the next falling edge would have occurred.
// Assumes: start is only pulsed while no frame is active and edge_target
// stays stable for the whole frame.
module adc_frame_seq #(
    parameter int SCLK_HALF = 2,
    parameter int FRAME_LEN = 16,
    localparam int FC_W     = $clog2(FRAME_LEN + 1),
    localparam int DIV_W    = $clog2(SCLK_HALF + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FC_W-1:0] edge_target,
    output logic            cs_n,
    output logic            sclk,
    output logic            rise_tick,
    output logic            ending,
    output logic [FC_W-1:0] falls
);

    logic             active_q;
    logic             sclk_q;
    logic [DIV_W-1:0] div_q;
    logic [FC_W-1:0]  falls_q;
    logic             half_done;

    // End of the current SCLK half period
    assign half_done = active_q && (div_q == DIV_W'(SCLK_HALF - 1));
    // The next edge would be a falling edge after the last wanted cycle
    assign ending    = half_done && sclk_q && (falls_q == edge_target);
    // The next edge raises SCLK: data is captured there
    assign rise_tick = half_done && !sclk_q;

    // Frame timing: divider, SCLK level, falling-edge count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            div_q    <= '0;
            falls_q  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b1;
            div_q    <= '0;
            falls_q  <= '0;
        end else if (active_q) begin
            if (half_done) begin
                div_q <= '0;
                if (ending) begin
                    active_q <= 1'b0;
                end else begin
                    sclk_q <= ~sclk_q;
                    if (sclk_q) begin
                        falls_q <= falls_q + 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign cs_n  = ~active_q;
    assign sclk  = sclk_q;
    assign falls = falls_q;

endmodule

// File: rtl/adc_rx_shift.sv
// Module: adc_rx_shift
// Serial-in shift register that gathers the bits of one frame, first bit
// ending up in the most significant position.
// Assumes: clear and shift_en are never high together.
module adc_rx_shift #(
    parameter int FRAME_LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 sdata_in,
    output logic [FRAME_LEN-1:0] word
);

    logic [FRAME_LEN-1:0] sh_q;

    // Capture one bit per SCLK rising edge
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= {sh_q[FRAME_LEN-2:0], sdata_in};
        end
    end

    assign word = sh_q;

endmodule

// File: rtl/adc_pwr_track.sv
// Module: adc_pwr_track
// Mirrors the converter's power state. The state is decided purely by how
// many SCLK falling edges a frame had when CS rose: an awake converter
// sleeps if CS rose within [SHUT_LO, WAKE_EDGE-1], and a sleeping one wakes
// once CS stayed low through WAKE_EDGE falls.
// Assumes: ending coincides with the clock in which CS returns high.
module adc_pwr_track #(
    parameter int FC_W      = 5,
    parameter int SHUT_LO   = 2,
    parameter int WAKE_EDGE = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            ending,
    input  logic [FC_W-1:0] falls,
    output logic            awake,
    output logic            awake_at_start
);

    logic awake_q;
    logic start_awake_q;
    logic in_sleep_win;
    logic past_wake;

    assign in_sleep_win = (falls >= FC_W'(SHUT_LO)) && (falls < FC_W'(WAKE_EDGE));
    assign past_wake    = (falls >= FC_W'(WAKE_EDGE));

    // Power state update at each CS rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake_q <= 1'b1;
        end else if (ending) begin
            if (awake_q && in_sleep_win) begin
                awake_q <= 1'b0;
            end else if (!awake_q && past_wake) begin
                awake_q <= 1'b1;
            end
        end
    end

    // Remember the power state at the CS fall of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_awake_q <= 1'b1;
        end else if (start) begin
            start_awake_q <= awake_q;
        end
    end

    assign awake          = awake_q;
    assign awake_at_start = start_awake_q;

endmodule

// File: rtl/adc_ctl.sv
// Module: adc_ctl (top)
// Host-side controller for a 12-bit serial SAR converter. It schedules
// conversion, wake and shutdown frames, enforces a CS-high gap that keeps
// the sample rate under MAX_SPS, and returns each valid sample with a
// one-cycle strobe.
// Assumes: the converter samples at CS fall, shifts a bit out after every
// SCLK fall, and is in normal mode after reset.
module adc_ctl
    import adc_ctl_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int FRAME_LEN  = 16,
    parameter int SCLK_HALF  = 2,
    parameter int CLK_HZ     = 50_000_000,
    parameter int MAX_SPS    = 250_000,
    parameter int GAP_MIN    = 8,
    parameter int SHUT_EDGES = 4,
    parameter int SHUT_LO    = 2,
    parameter int WAKE_EDGE  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              sd_req,
    input  logic              sleep_en,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              pwr_awake,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_sdata
);

    localparam int FC_W       = $clog2(FRAME_LEN + 1);
    localparam int MIN_PERIOD = (CLK_HZ + MAX_SPS - 1) / MAX_SPS;
    localparam int FRAME_CLKS = (2 * FRAME_LEN + 1) * SCLK_HALF;
    localparam int RATE_GAP   = (MIN_PERIOD > FRAME_CLKS) ? (MIN_PERIOD - FRAME_CLKS) : 0;
    localparam int GAP_EFF    = (RATE_GAP > GAP_MIN) ? RATE_GAP : GAP_MIN;
    localparam int GAP_W      = $clog2(GAP_EFF + 1);

    ctl_state_e        state_q;
    frame_kind_e       kind_q;
    frame_kind_e       start_kind;
    logic              start;
    logic              pend_conv_q;
    logic              pend_shut_q;
    logic [GAP_W-1:0]  gap_q;
    logic              gap_last;
    logic [FC_W-1:0]   edge_target;
    logic              rise_tick;
    logic              ending;
    logic [FC_W-1:0]   falls;
    logic [FRAME_LEN-1:0] rx_word;
    logic              awake;
    logic              awake_at_start;
    logic              res_valid_q;
    logic [DATA_W-1:0] res_data_q;

    assign gap_last    = (gap_q == GAP_W'(GAP_EFF - 1));
    assign edge_target = (kind_q == FK_SHUT) ? FC_W'(SHUT_EDGES) : FC_W'(FRAME_LEN);

    // Decide whether a frame starts this cycle and which kind
    always_comb begin
        start      = 1'b0;
        start_kind = FK_CONV;
        case (state_q)
            ST_GAP: begin
                if (gap_last && pend_conv_q) begin
                    start      = 1'b1;
                    start_kind = FK_CONV;
                end else if (gap_last && pend_shut_q) begin
                    start      = 1'b1;
                    start_kind = FK_SHUT;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    start      = 1'b1;
                    start_kind = awake ? FK_CONV : FK_WAKE;
                end else if (sd_req && awake) begin
                    start      = 1'b1;
                    start_kind = FK_SHUT;
                end
            end
            default: begin
                start = 1'b0;
            end
        endcase
    end

    // Sequencing state, gap counter and owed frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_GAP;
            kind_q      <= FK_CONV;
            pend_conv_q <= 1'b0;
            pend_shut_q <= 1'b0;
            gap_q       <= '0;
        end else begin
            case (state_q)
                ST_GAP: begin
                    if (gap_last) begin
                        gap_q   <= '0;
                        state_q <= start ? ST_FRAME : ST_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (ending) begin
                        state_q <= ST_GAP;
                        if (kind_q == FK_CONV) begin
                            pend_shut_q <= sleep_en;
                        end
                    end
                end
                default: begin
                    state_q <= ST_GAP;
                end
            endcase
            if (start) begin
                kind_q <= start_kind;
                case (start_kind)
                    FK_CONV: pend_conv_q <= 1'b0;
                    FK_WAKE: pend_conv_q <= 1'b1;
                    FK_SHUT: pend_shut_q <= 1'b0;
                    default: pend_conv_q <= pend_conv_q;
                endcase
            end
        end
    end

    adc_frame_seq #(
        .SCLK_HALF (SCLK_HALF),
        .FRAME_LEN (FRAME_LEN)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .edge_target (edge_target),
        .cs_n        (adc_cs_n),
        .sclk        (adc_sclk),
        .rise_tick   (rise_tick),
        .ending      (ending),
        .falls       (falls)
    );

    adc_rx_shift #(
        .FRAME_LEN (FRAME_LEN)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .shift_en (rise_tick),
        .sdata_in (adc_sdata),
        .word     (rx_word)
    );

    adc_pwr_track #(
        .FC_W      (FC_W),
        .SHUT_LO   (SHUT_LO),
        .WAKE_EDGE (WAKE_EDGE)
    ) u_pwr (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .ending         (ending),
        .falls          (falls),
        .awake          (awake),
        .awake_at_start (awake_at_start)
    );

    // Result strobe: only complete conversion frames begun while awake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
        end else begin
            res_valid_q <= ending && (kind_q == FK_CONV) && awake_at_start
                           && (falls == FC_W'(FRAME_LEN));
            if (ending && (kind_q == FK_CONV)) begin
                res_data_q <= rx_word[DATA_W-1:0];
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;
    assign pwr_awake = awake;

endmodule

// File: rtl/adc_ctl_chk.sv
// Module: adc_ctl_chk
// Protocol checker attached to adc_ctl. It counts SCLK falls and CS-high
// cycles from the pins and checks power-state and result timing.
// Assumes: bound to adc_ctl, MIN_GAP set to the controller's gap.
module adc_ctl_chk #(
    parameter int MIN_GAP   = 8,
    parameter int SHUT_LO   = 2,
    parameter int WAKE_EDGE = 10
) (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic res_valid,
    input logic req_ready,
    input logic pwr_awake
);

    logic        cs_d;
    logic        sclk_d;
    logic [7:0]  fcnt;
    logic [15:0] hcnt;

    // Falling-edge count of the current or last frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b1;
            fcnt   <= '0;
        end else begin
            cs_d   <= adc_cs_n;
            sclk_d <= adc_sclk;
            if (cs_d && !adc_cs_n) begin
                fcnt <= '0;
            end else if (!adc_cs_n && sclk_d && !adc_sclk && fcnt != 8'hFF) begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    // CS-high run length, saturating; reset counts as a long gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= 16'hFFFF;
        end else if (adc_cs_n) begin
            if (hcnt != 16'hFFFF) hcnt <= hcnt + 1'b1;
        end else begin
            hcnt <= '0;
        end
    end

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);                                         // R2
    AST_RESULT_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));                                 // R2
    AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> adc_cs_n);                                        // R3
    AST_RESULT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> pwr_awake);                                       // R6
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hcnt >= 16'(MIN_GAP)));                    // R8
    AST_SLEEP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_awake) |-> (fcnt >= 8'(SHUT_LO) && fcnt < 8'(WAKE_EDGE))); // R10
    AST_WAKE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_awake) |-> (fcnt >= 8'(WAKE_EDGE)));                  // R10
    AST_PWR_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_awake != $past(pwr_awake)) |-> $rose(adc_cs_n));           // R10

endmodule

bind adc_ctl adc_ctl_chk #(
    .MIN_GAP   (GAP_EFF),
    .SHUT_LO   (SHUT_LO),
    .WAKE_EDGE (WAKE_EDGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .res_valid (res_valid),
    .req_ready (req_ready),
    .pwr_awake (pwr_awake)
);

// File: tb/adc_ctl_tb.sv
// Bench for adc_ctl: behavioural converter model with its own power rules
// and an expected-result queue, compared with the outputs on every clock.
module adc_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 12;
    localparam int SCLK_HALF  = 2;
    localparam int CLK_HZ     = 50_000_000;
    localparam int MAX_SPS    = 250_000;
    localparam int GAP_MIN    = 8;
    localparam int MIN_PER    = (CLK_HZ + MAX_SPS - 1) / MAX_SPS;
    localparam int FULL_LOW   = 33 * SCLK_HALF;
    localparam int EXP_GAP    = (MIN_PER - FULL_LOW > GAP_MIN) ? (MIN_PER - FULL_LOW) : GAP_MIN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic sd_req = 1'b0;
    logic sleep_en = 1'b0;
    logic adc_sdata = 1'b0;
    logic req_ready, res_valid, pwr_awake, adc_cs_n, adc_sclk;
    logic [DATA_W-1:0] res_data;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_ctl #(
        .DATA_W    (DATA_W),
        .SCLK_HALF (SCLK_HALF),
        .CLK_HZ    (CLK_HZ),
        .MAX_SPS   (MAX_SPS),
        .GAP_MIN   (GAP_MIN)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .sd_req    (sd_req),
        .sleep_en  (sleep_en),
        .res_valid (res_valid),
        .res_data  (res_data),
        .pwr_awake (pwr_awake),
        .adc_cs_n  (adc_cs_n),
        .adc_sclk  (adc_sclk),
        .adc_sdata (adc_sdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    bit        m_awake = 1'b1;
    bit        m_awake_f = 1'b0;
    int        m_falls = 0;
    int        m_idx = 0;
    int        m_last_falls = 0;
    logic [15:0] m_word = '0;
    logic [DATA_W-1:0] exp_q[$];

    always @(negedge adc_cs_n) begin
        m_falls   = 0;
        m_awake_f = m_awake;
        m_idx++;
        m_word    = m_awake ? {4'b0000, 12'((m_idx * 937 + 347) % 4096)} : 16'hFFFF;
        adc_sdata = 1'b0;
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            m_falls++;
            adc_sdata = (m_falls <= 16) ? m_word[16 - m_falls] : 1'b0;
        end
    end

    always @(posedge adc_cs_n) begin
        if (m_awake && m_falls >= 2 && m_falls < 10) begin
            m_awake = 1'b0;
            check(m_falls == 4, "R4 shutdown edge count", m_falls, 4);
        end else if (!m_awake && m_falls >= 10) begin
            m_awake = 1'b1;
        end
        if (m_awake_f && m_falls == 16) exp_q.push_back(m_word[11:0]);
        m_awake_f    = 1'b0;
        m_last_falls = m_falls;
        adc_sdata    = 1'b0;
    end

    // ---------------- per-clock comparison ----------------
    int  cyc = 0;
    int  hc = 1000;
    int  last_fall = -1;
    int  n_frames = 0;
    int  n_res = 0;
    bit  prev_cs = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(pwr_awake == m_awake, "R10 power state", pwr_awake, m_awake);
            if (adc_cs_n) check(adc_sclk == 1'b1, "R2 sclk parked high", adc_sclk, 1);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected result", res_data, -1);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(res_data == e, "R2 result data", res_data, e);
                    n_res++;
                end
            end
            if (prev_cs && !adc_cs_n) begin
                check(hc >= EXP_GAP, "R8 cs high gap", hc, EXP_GAP);
                if (last_fall >= 0 && m_last_falls == 16)
                    check(cyc - last_fall >= MIN_PER, "R8 frame rate", cyc - last_fall, MIN_PER);
                last_fall = cyc;
                n_frames++;
            end
        end
        hc      = adc_cs_n ? hc + 1 : 0;
        prev_cs = adc_cs_n;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_ready();
        for (int t = 0; t < 5000 && !req_ready; t++) @(negedge clk);
    endtask

    task automatic do_req();
        wait_ready();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready && !adc_cs_n, "R3 frame starts after handshake", adc_cs_n, 0);
        @(negedge clk);
        wait_ready();
    endtask

    task automatic wait_asleep();
        for (int t = 0; t < 5000 && pwr_awake; t++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int f0;
        int r0;
        int r_at_sleep;
        repeat (4) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 cs_n in reset", adc_cs_n, 1);
        check(adc_sclk == 1'b1, "R1 sclk in reset", adc_sclk, 1);
        check(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_cs_n && adc_sclk && !res_valid, "R1 outputs after reset", adc_cs_n, 1);
        check(pwr_awake == 1'b1, "R1 power after reset", pwr_awake, 1);

        // R2 R3: conversions while awake
        for (int k = 0; k < 3; k++) begin
            r0 = n_res;
            do_req();
            check(n_res == r0 + 1, "R2 one result per request", n_res, r0 + 1);
        end
        check(pwr_awake == 1'b1, "R2 stays awake", pwr_awake, 1);

        // R4: shutdown request
        r0 = n_res;
        f0 = n_frames;
        wait_ready();
        sd_req = 1'b1;
        wait_asleep();
        sd_req = 1'b0;
        wait_ready();
        check(pwr_awake == 1'b0, "R4 asleep after shutdown", pwr_awake, 0);
        check(n_res == r0, "R4 no result from shutdown", n_res, r0);
        check(n_frames == f0 + 1, "R4 one shutdown frame", n_frames, f0 + 1);

        // R5: shutdown request while asleep is ignored
        f0 = n_frames;
        sd_req = 1'b1;
        repeat (400) @(negedge clk);
        sd_req = 1'b0;
        check(n_frames == f0, "R5 no frame while asleep", n_frames, f0);
        check(adc_cs_n == 1'b1, "R5 cs stays high", adc_cs_n, 1);

        // R6: request while asleep wakes first
        r0 = n_res;
        f0 = n_frames;
        do_req();
        check(n_res == r0 + 1, "R6 single result after wake", n_res, r0 + 1);
        check(n_frames == f0 + 2, "R6 wake plus conversion frames", n_frames, f0 + 2);
        check(pwr_awake == 1'b1, "R6 awake after wake", pwr_awake, 1);

        // R7: sleep between samples
        sleep_en = 1'b1;
        r0 = n_res;
        f0 = n_frames;
        do_req();
        check(pwr_awake == 1'b0, "R7 asleep after sample", pwr_awake, 0);
        check(n_frames == f0 + 2, "R7 conversion plus shutdown", n_frames, f0 + 2);
        do_req();
        check(pwr_awake == 1'b0, "R7 asleep after second sample", pwr_awake, 0);
        check(n_frames == f0 + 5, "R7 wake conversion shutdown", n_frames, f0 + 5);
        check(n_res == r0 + 2, "R7 results", n_res, r0 + 2);
        sleep_en = 1'b0;

        // R9: sample and shutdown request in the same idle cycle
        do_req();
        check(pwr_awake == 1'b1, "R9 awake before collision", pwr_awake, 1);
        r0 = n_res;
        f0 = n_frames;
        wait_ready();
        req_valid = 1'b1;
        sd_req    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_asleep();
        r_at_sleep = n_res;
        sd_req = 1'b0;
        wait_ready();
        check(r_at_sleep == r0 + 1, "R9 sample before shutdown", r_at_sleep, r0 + 1);
        check(n_frames == f0 + 2, "R9 two frames", n_frames, f0 + 2);
        check(pwr_awake == 1'b0, "R9 asleep at end", pwr_awake, 0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 all expected results seen", exp_q.size(), 0);
        finish_run();
    end

endmodule